// File: doc/BRIEF.md
# Daisy-Chained Interrupt Priority Node

This block is the interrupt arbitration link placed inside a peripheral. Several copies are wired in series: an enable-in line comes from the node above, and an enable-out line goes to the node below. The head node has its enable-in tied high. Priority comes only from position: a node closer to the head beats every node after it. A node with a live request, or one that is still being serviced, pulls its enable-out low. This silences everything below it until its service routine returns.

The peripheral signals an event with a one-cycle strobe, and a per-node mask can hold that event back. The request output is active high and is meant to be OR-combined with the other nodes' requests, the way a shared open-drain line works. The CPU acknowledges a request by asserting its fetch strobe and its I/O strobe in the same cycle. In that cycle the winning node places an 8-bit vector on its data output with bit 0 forced to zero. The winner then enters service. It stays in service until a decoded return-from-interrupt strobe arrives while its enable-in is high, so a higher node can interrupt it and nest above it.

Top module: `irq_chain_node`

## Requirements
- R1: While reset is high and in the first cycle after it, the node holds no pending event and no service state, so enable-out equals enable-in and the request is low.
- R2: Enable-out equals enable-in AND NOT (unmasked pending OR in service), combinationally.
- R3: The request output is high exactly when enable-in is high, an unmasked event is pending, and the node is not in service.
- R4: A one-cycle event strobe sets the pending flag from the next cycle. Repeated strobes merge into one pending event. A pending event under mask neither requests nor blocks, and it is kept until the mask is lowered.
- R5: An acknowledge is a cycle with both the fetch strobe and the I/O strobe high. In an acknowledge cycle a requesting node raises vector-valid and drives {vector-select, 1'b0}. At all other times vector-valid is low and the vector output is zero.
- R6: After winning an acknowledge, the node's pending flag is cleared and the node is in service from the next cycle.
- R7: A return strobe leaves service only when it arrives while enable-in is high. With enable-in low, the return strobe has no effect.
- R8: A node above one that is in service may request, win and be serviced. The lower node stays in service through this and leaves only on its own later return.
- R9: When several nodes have events pending at once, only the one nearest the head requests and wins. The others request in chain order as each service above them ends.
- R10: An event strobe in the same cycle as the node's own winning acknowledge leaves the node pending again, and it is still in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 1 | One-cycle event strobe from the peripheral |
| mask_i | input | 1 | High holds the pending event back |
| vec_sel_i | input | VEC_W-1 | Upper bits of the vector |
| ei_i | input | 1 | Enable-in from the node above (tie high at the head) |
| eo_o | output | 1 | Enable-out to the node below |
| int_req_o | output | 1 | Request to the CPU, to be OR-combined |
| m1_i | input | 1 | CPU fetch-cycle strobe |
| iorq_i | input | 1 | CPU I/O request strobe |
| reti_i | input | 1 | Decoded return-from-interrupt strobe |
| vec_o | output | VEC_W | Vector, zero when not valid |
| vec_oe_o | output | 1 | Vector valid, high only in a winning acknowledge cycle |

## Verification
The checker assumes that the acknowledge and return strobes last one cycle each and never coincide. It also assumes that an acknowledge happens only while some node in the chain is requesting, and that the enable-in lines settle combinationally within the cycle. The bench drives three chained nodes from one sequential script, so it produces each strobe for exactly one cycle. It issues an acknowledge only after a request is visible. It also sends stray returns when no node is in service, to check that the return strobe is ignored there.

// File: rtl/irq_node_pkg.sv
package irq_node_pkg;

    localparam int unsigned VEC_W_DEF = 8;

    typedef struct packed {
        logic fetch;
        logic io;
        logic ret;
    } cpu_cyc_t;

    typedef struct packed {
        logic pend;
        logic serv;
    } node_state_t;

    function automatic logic is_ack(input cpu_cyc_t c);
        return c.fetch & c.io;
    endfunction

    function automatic logic blocks_chain(input node_state_t s, input logic masked);
        return (s.pend & ~masked) | s.serv;
    endfunction

endpackage

// File: rtl/node_pend.sv
module node_pend (
    input  logic clk,
    input  logic rst,
    input  logic evt_i,
    input  logic win_i,
    output logic pend_o
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= (pend_q & ~win_i) | evt_i;
        end
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/node_serv.sv
module node_serv (
    input  logic clk,
    input  logic rst,
    input  logic win_i,
    input  logic ret_i,
    input  logic ei_i,
    output logic serv_o
);
    logic serv_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            serv_q <= 1'b0;
        end else if (win_i) begin
            serv_q <= 1'b1;
        end else if (ret_i && ei_i) begin
            serv_q <= 1'b0;
        end
    end

    assign serv_o = serv_q;
endmodule

// File: rtl/node_vec.sv
module node_vec #(
    parameter int unsigned VEC_W = 8
) (
    input  logic             win_i,
    input  logic [VEC_W-2:0] sel_i,
    output logic [VEC_W-1:0] vec_o,
    output logic             oe_o
);
    genvar b;
    generate
        for (b = 0; b < VEC_W; b++) begin : g_bit
            if (b == 0) begin : g_lsb
                assign vec_o[b] = 1'b0;
            end else begin : g_upper
                assign vec_o[b] = win_i & sel_i[b-1];
            end
        end
    endgenerate

    assign oe_o = win_i;
endmodule

// File: rtl/irq_chain_node.sv
module irq_chain_node
    import irq_node_pkg::*;
#(
    parameter int unsigned VEC_W = VEC_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt_i,
    input  logic             mask_i,
    input  logic [VEC_W-2:0] vec_sel_i,
    input  logic             ei_i,
    output logic             eo_o,
    output logic             int_req_o,
    input  logic             m1_i,
    input  logic             iorq_i,
    input  logic             reti_i,
    output logic [VEC_W-1:0] vec_o,
    output logic             vec_oe_o
);
    localparam int unsigned SEL_W = VEC_W - 1;

    cpu_cyc_t    cyc;
    node_state_t st;
    logic        req_ok;
    logic        win;
    logic [SEL_W-1:0] sel;

    assign cyc = '{fetch: m1_i, io: iorq_i, ret: reti_i};
    assign sel = vec_sel_i;

    node_pend u_pend (
        .clk    (clk),
        .rst    (rst),
        .evt_i  (evt_i),
        .win_i  (win),
        .pend_o (st.pend)
    );

    node_serv u_serv (
        .clk    (clk),
        .rst    (rst),
        .win_i  (win),
        .ret_i  (cyc.ret),
        .ei_i   (ei_i),
        .serv_o (st.serv)
    );

    assign req_ok    = ei_i & st.pend & ~mask_i & ~st.serv;
    assign win       = req_ok & is_ack(cyc);
    assign eo_o      = ei_i & ~blocks_chain(st, mask_i);
    assign int_req_o = req_ok;

    node_vec #(.VEC_W(VEC_W)) u_vec (
        .win_i (win),
        .sel_i (sel),
        .vec_o (vec_o),
        .oe_o  (vec_oe_o)
    );
endmodule

// File: rtl/irq_chain_node_chk.sv
module irq_chain_node_chk (
    input logic clk,
    input logic rst,
    input logic ei_i,
    input logic eo_o,
    input logic int_req_o,
    input logic vec_oe_o,
    input logic m1_i,
    input logic iorq_i,
    input logic reti_i,
    input logic serv
);
    AST_SERV_LOCKS_BELOW: assert property (@(posedge clk) disable iff (rst)
        serv |-> !eo_o); // R2

    AST_NO_ENABLE_NO_OUT: assert property (@(posedge clk) disable iff (rst)
        !ei_i |-> (!eo_o && !int_req_o)); // R3

    AST_REQ_IMPLIES_BLOCK: assert property (@(posedge clk) disable iff (rst)
        int_req_o |-> !eo_o); // R9

    AST_NO_REQ_IN_SERV: assert property (@(posedge clk) disable iff (rst)
        serv |-> !int_req_o); // R3

    AST_VEC_IN_ACK_ONLY: assert property (@(posedge clk) disable iff (rst)
        vec_oe_o |-> (m1_i && iorq_i && int_req_o)); // R5

    AST_WIN_ENTERS_SERV: assert property (@(posedge clk) disable iff (rst)
        vec_oe_o |=> serv); // R6

    AST_RET_LEAVES_SERV: assert property (@(posedge clk) disable iff (rst)
        (reti_i && ei_i && serv && !vec_oe_o) |=> !serv); // R7

    AST_RET_BLOCKED_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (reti_i && !ei_i && serv) |=> serv); // R8
endmodule

bind irq_chain_node irq_chain_node_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ei_i      (ei_i),
    .eo_o      (eo_o),
    .int_req_o (int_req_o),
    .vec_oe_o  (vec_oe_o),
    .m1_i      (m1_i),
    .iorq_i    (iorq_i),
    .reti_i    (reti_i),
    .serv      (st.serv)
);

// File: tb/sim_irq_chain_node.sv
module sim_irq_chain_node;
    localparam int N = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [N-1:0] evt = '0;
    logic [N-1:0] mask = '0;
    logic m1 = 1'b0, iorq = 1'b0, reti = 1'b0;
    logic [N:0] chain;
    logic [N-1:0] req, oe;
    logic [7:0] vec [N];

    int checks = 0;
    int errors = 0;

    assign chain[0] = 1'b1;

    irq_chain_node #(.VEC_W(8)) u0 (
        .clk(clk), .rst(rst), .evt_i(evt[0]), .mask_i(mask[0]), .vec_sel_i(7'h10),
        .ei_i(chain[0]), .eo_o(chain[1]), .int_req_o(req[0]),
        .m1_i(m1), .iorq_i(iorq), .reti_i(reti), .vec_o(vec[0]), .vec_oe_o(oe[0]));
    irq_chain_node #(.VEC_W(8)) u1 (
        .clk(clk), .rst(rst), .evt_i(evt[1]), .mask_i(mask[1]), .vec_sel_i(7'h25),
        .ei_i(chain[1]), .eo_o(chain[2]), .int_req_o(req[1]),
        .m1_i(m1), .iorq_i(iorq), .reti_i(reti), .vec_o(vec[1]), .vec_oe_o(oe[1]));
    irq_chain_node #(.VEC_W(8)) u2 (
        .clk(clk), .rst(rst), .evt_i(evt[2]), .mask_i(mask[2]), .vec_sel_i(7'h5A),
        .ei_i(chain[2]), .eo_o(chain[3]), .int_req_o(req[2]),
        .m1_i(m1), .iorq_i(iorq), .reti_i(reti), .vec_o(vec[2]), .vec_oe_o(oe[2]));

    // behavioural reference state
    int pend_m [N];
    int serv_m [N];
    int en_m   [N];
    int oe_m   [N];
    int sel_m  [N];

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // compare every output against the model for current inputs
    task automatic compare(input string tag_eo, input string tag_req);
        int en;
        int live, e_req, e_eo, e_vec;
        en = 1;
        for (int i = 0; i < N; i++) begin
            live  = pend_m[i] & ~int'(mask[i]) & 1;
            e_req = en & live & (serv_m[i] ? 0 : 1);
            e_eo  = en & ((live | serv_m[i]) ? 0 : 1);
            en_m[i] = en;
            oe_m[i] = e_req & int'(m1 & iorq);
            e_vec = oe_m[i] ? (sel_m[i] << 1) : 0;
            chk(chain[i+1] == e_eo[0], tag_eo, $sformatf("eo node%0d", i), chain[i+1], e_eo);
            chk(req[i] == e_req[0], tag_req, $sformatf("req node%0d", i), req[i], e_req);
            chk(oe[i] == oe_m[i][0], "R5/R9", $sformatf("vec_oe node%0d", i), oe[i], oe_m[i]);
            chk(vec[i] == e_vec[7:0], "R5", $sformatf("vec node%0d", i), vec[i], e_vec);
            en = e_eo;
        end
    endtask

    task automatic model_update();
        for (int i = 0; i < N; i++) begin
            if (rst) begin
                pend_m[i] = 0;
                serv_m[i] = 0;
            end else begin
                if (oe_m[i] != 0) begin
                    pend_m[i] = 0;
                    serv_m[i] = 1;
                end else if (reti && en_m[i] != 0) begin
                    serv_m[i] = 0;
                end
                if (evt[i]) pend_m[i] = 1;
            end
        end
    endtask

    task automatic cyc(input logic [N-1:0] e, input logic a, input logic r);
        evt = e; m1 = a; iorq = a; reti = r;
        #1;
        compare("R2", "R3");
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        sel_m[0] = 'h10; sel_m[1] = 'h25; sel_m[2] = 'h5A;
        for (int i = 0; i < N; i++) begin pend_m[i] = 0; serv_m[i] = 0; end
        @(negedge clk);
        repeat (3) begin
            @(posedge clk); model_update(); @(negedge clk);
        end
        #1 compare("R1", "R1"); // R1 reset state
        rst = 1'b0;
        cyc('0, 0, 0); // R1 first cycle after reset

        // single event on the tail node: R4 R5 R6 R7
        cyc(3'b100, 0, 0);
        cyc('0, 0, 0);
        cyc('0, 1, 0);
        cyc('0, 0, 0);
        cyc('0, 0, 1);
        cyc('0, 0, 0);

        // simultaneous events, head wins first: R9
        cyc(3'b101, 0, 0);
        cyc('0, 1, 0);
        cyc('0, 0, 0);
        cyc('0, 0, 1);
        cyc('0, 0, 0);
        cyc('0, 1, 0);
        cyc('0, 0, 1);
        cyc('0, 0, 0);

        // nesting: R8 (middle node in service, head interrupts)
        cyc(3'b010, 0, 0);
        cyc('0, 1, 0);
        cyc(3'b001, 0, 0);
        cyc('0, 0, 0);
        cyc('0, 1, 0);
        cyc('0, 0, 1);  // head returns, middle stays in service
        cyc('0, 0, 0);
        cyc('0, 0, 1);  // middle returns
        cyc('0, 0, 0);

        // mask: R4 masked pending neither requests nor blocks
        mask = 3'b010;
        cyc(3'b010, 0, 0);
        cyc(3'b010, 0, 0);  // merged strobe
        cyc(3'b100, 0, 0);
        cyc('0, 1, 0);      // tail wins past masked middle
        mask = 3'b000;
        cyc('0, 0, 0);      // middle now requests while tail in service
        cyc('0, 1, 0);
        cyc('0, 0, 1);      // middle returns
        cyc('0, 0, 1);      // tail returns
        cyc('0, 0, 1);      // stray return with none in service: R7
        cyc('0, 0, 0);

        // event during own winning acknowledge: R10
        cyc(3'b001, 0, 0);
        cyc(3'b001, 1, 0);
        cyc('0, 0, 0);
        cyc('0, 0, 1);
        cyc('0, 0, 0);
        cyc('0, 1, 0);
        cyc('0, 0, 1);
        repeat (3) cyc('0, 0, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule